// File: doc/BRIEF.md
# Generation-Bit Event Ring

This block is a single-producer, single-consumer ring of 32-bit event words that serves one thread at one priority level. The producer side takes an interrupt number and stores it in the next slot. The slot's top bit is set to a generation value, and the producer flips that value each time its write pointer laps the ring. The consumer never sees the producer's pointer. It decides whether the slot under its own index holds a fresh event by comparing that slot's top bit with a parity toggle it keeps for itself, and it flips the toggle each time its index laps.

The consumer reads the head of the ring through a combinational port. That port gives the stored number, or zero plus an empty flag when nothing new is waiting. A pop request moves the consumer past the head on the next clock edge. Every accepted write raises a one-cycle notify pulse. A write that would land on an unread slot is dropped, and a sticky overflow flag is raised. One code, 2^24, is reserved to mark an inter-processor event, and the head port flags it.

Top module: `gen_event_ring`

## Requirements
- R1: After reset the ring holds all zeros, `popEmpty` is 1, `popData` is 0, and `notify`, `overflow` and `popIsIpi` are 0.
- R2: Each slot stores the generation bit in bit 31 and the event number in bits 30:0. Events leave in the order they were accepted, and `popData` shows bits 30:0 of the head slot from the cycle after its write edge.
- R3: When `DEPTH` unread entries are stored, a write without an accepted pop in the same cycle is dropped, the stored entries are left unchanged, and `overflow` goes to 1 on the next cycle and stays there until reset.
- R4: `notify` is high for exactly the one cycle that follows each accepted write.
- R5: The head is empty when its bit 31 equals the consumer toggle. The writer's generation starts at 1 and the toggle starts at 0. When the head is empty, `popEmpty` is 1 and `popData` is 0.
- R6: A pop request while the ring is empty does not move the consumer, and no later event is lost or skipped.
- R7: Both indices wrap modulo `DEPTH`, a power of two. The writer generation inverts when the write index wraps to 0, and the consumer toggle inverts when the read index wraps to 0. Entries left over from an earlier lap never appear valid.
- R8: `popIsIpi` is 1 exactly when the head is valid and its number equals 2^24.
- R9: When the ring is full, a write and a pop in the same cycle are both accepted and `overflow` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Producer offers an event this cycle |
| evtNum | input | 31 | Event number to store |
| popReq | input | 1 | Consumer asks to move past the head |
| popData | output | 31 | Head event number, 0 when empty |
| popEmpty | output | 1 | No fresh entry at the consumer index |
| popIsIpi | output | 1 | Head holds the reserved inter-processor code |
| notify | output | 1 | One-cycle pulse after each accepted write |
| overflow | output | 1 | Sticky: a write was dropped on a full ring |

## Verification
The assertions assume that reset is applied before the first event and that `evtValid` and `popReq` carry known values on every clock edge. `DEPTH` must be a power of two of at least 2, because the wrap and generation checks rely on the natural rollover of the index. Pop requests may come at any time, including on an empty ring. The stimulus keeps inputs driven at all times, changes them only at the falling edge, and mixes empty pops, full-ring writes and same-cycle write-plus-pop over many laps, so the generation logic is exercised in both polarities.

// File: rtl/gen_event_ring_pkg.sv
package gen_event_ring_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_W   = WORD_W - 1;
  localparam logic [NUM_W-1:0] IPI_CODE = NUM_W'(1) << 24;

  typedef struct packed {
    logic wrEn;      // store a word this edge
    logic wrGen;     // generation bit for the stored word
    logic popEn;     // consumer advances this edge
    logic rdToggle;  // consumer parity for validity compare
  } ringStrobes_t;
endpackage

// File: rtl/gen_event_ring_ctrl.sv
module gen_event_ring_ctrl
  import gen_event_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evtValid,
  input  logic             popReq,
  input  logic             headEmpty,
  output ringStrobes_t     strobes,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             notify,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic             wrGen;
  logic             rdToggle;
  logic [CNT_W-1:0] fill;
  logic             popOk;
  logic             wrOk;
  logic             isFull;

  assign isFull = (fill == FULL_CNT);
  assign popOk  = popReq && !headEmpty;
  assign wrOk   = evtValid && (!isFull || popOk);

  always_comb begin
    strobes.wrEn     = wrOk;
    strobes.wrGen    = wrGen;
    strobes.popEn    = popOk;
    strobes.rdToggle = rdToggle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrIdx    <= '0;
      wrGen    <= 1'b1;
      rdIdx    <= '0;
      rdToggle <= 1'b0;
      fill     <= '0;
      notify   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      notify <= wrOk;
      if (evtValid && !wrOk) overflow <= 1'b1;
      if (wrOk) begin
        wrIdx <= wrIdx + 1'b1;
        if (wrIdx == LAST_IDX) wrGen <= ~wrGen;
      end
      if (popOk) begin
        rdIdx <= rdIdx + 1'b1;
        if (rdIdx == LAST_IDX) rdToggle <= ~rdToggle;
      end
      case ({wrOk, popOk})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R5: generation compare in the datapath agrees with the occupancy count
  a_r5_gen_matches_fill: assert property (@(posedge clk) disable iff (!rst_n)
    headEmpty == (fill == '0));

  // R3: a write offered to a full ring with no pop raises the flag
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (isFull && evtValid && !popReq) |=> overflow);

  // R3: flag is sticky
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R6: empty pop leaves the consumer index alone
  a_r6_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (popReq && headEmpty) |=> $stable(rdIdx));

  // R4: a notify pulse always leaves something in the ring
  a_r4_notify_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> !headEmpty);

  // R7: occupancy never exceeds the ring size
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_CNT);
endmodule

// File: rtl/gen_event_ring_data.sv
module gen_event_ring_data
  import gen_event_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ringStrobes_t     strobes,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [NUM_W-1:0] evtNum,
  output logic             headEmpty,
  output logic [NUM_W-1:0] headNum,
  output logic             headIpi
);
  logic [WORD_W-1:0] slots [DEPTH];
  logic [WORD_W-1:0] headWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) slots[i] <= '0;
    end else if (strobes.wrEn) begin
      slots[wrIdx] <= {strobes.wrGen, evtNum};
    end
  end

  assign headWord  = slots[rdIdx];
  assign headEmpty = (headWord[WORD_W-1] == strobes.rdToggle);
  assign headNum   = headEmpty ? '0 : headWord[NUM_W-1:0];
  assign headIpi   = !headEmpty && (headWord[NUM_W-1:0] == IPI_CODE);

  // R8: the reserved code is only flagged on a valid head
  a_r8_ipi_valid: assert property (@(posedge clk) disable iff (!rst_n)
    headIpi |-> (headNum == IPI_CODE));
endmodule

// File: rtl/gen_event_ring.sv
module gen_event_ring
  import gen_event_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evtValid,
  input  logic [30:0] evtNum,
  input  logic        popReq,
  output logic [30:0] popData,
  output logic        popEmpty,
  output logic        popIsIpi,
  output logic        notify,
  output logic        overflow
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  ringStrobes_t     strobes;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             headEmpty;

  gen_event_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .popReq(popReq),
    .headEmpty(headEmpty), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .notify(notify), .overflow(overflow)
  );

  gen_event_ring_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .evtNum(evtNum), .headEmpty(headEmpty), .headNum(popData), .headIpi(popIsIpi)
  );

  assign popEmpty = headEmpty;
endmodule

// File: tb/gen_event_ring_bench.sv
module gen_event_ring_bench;
  localparam int DEPTH = 16;
  localparam logic [30:0] IPI = 31'h100_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evtValid = 1'b0;
  logic [30:0] evtNum = '0;
  logic popReq = 1'b0;
  logic [30:0] popData;
  logic popEmpty, popIsIpi, notify, overflow;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [30:0] model [$];
  bit expNotify = 1'b0;
  bit expOvf = 1'b0;

  gen_event_ring #(.DEPTH(DEPTH)) u_gen_event_ring (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtNum(evtNum),
    .popReq(popReq), .popData(popData), .popEmpty(popEmpty),
    .popIsIpi(popIsIpi), .notify(notify), .overflow(overflow)
  );

  always #5 clk = ~clk;

  function automatic logic [30:0] expData();
    return (model.size() == 0) ? 31'd0 : model[0];
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic checkAll();
    check("R5 empty", 32'(popEmpty), 32'(model.size() == 0));
    check("R2 data", 32'(popData), 32'(expData()));
    check("R8 ipi", 32'(popIsIpi), 32'(model.size() != 0 && model[0] == IPI));
    check("R4 notify", 32'(notify), 32'(expNotify));
    check("R3 overflow", 32'(overflow), 32'(expOvf));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit ev, logic [30:0] n, bit pp);
    bit popOk, wrOk;
    evtValid = ev; evtNum = n; popReq = pp;
    popOk = pp && (model.size() > 0);
    wrOk  = ev && ((model.size() < DEPTH) || popOk);
    @(posedge clk);
    @(negedge clk);
    if (popOk) void'(model.pop_front());
    if (wrOk) model.push_back(n);
    expNotify = wrOk;
    if (ev && !wrOk) expOvf = 1'b1;
    evtValid = 1'b0; popReq = 1'b0;
    checkAll();
  endtask

  initial begin
    #(200000 * 10);
    nTests++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int seed;
    logic [30:0] v;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 popEmpty", 32'(popEmpty), 32'd1);
    check("R1 popData", 32'(popData), 32'd0);
    check("R1 notify", 32'(notify), 32'd0);
    check("R1 overflow", 32'(overflow), 32'd0);
    check("R1 popIsIpi", 32'(popIsIpi), 32'd0);

    // R6: pops on empty ring, then an event must be seen
    step(0, '0, 1);
    step(0, '0, 1);
    check("R6 still empty", 32'(popEmpty), 32'd1);
    step(1, 31'h1234, 1);
    check("R6 event visible", 32'(popData), 32'h1234);
    step(0, '0, 1);

    // R8: reserved code and a neighbour
    step(1, IPI, 0);
    check("R8 ipi flagged", 32'(popIsIpi), 32'd1);
    step(1, IPI + 1, 1);
    check("R8 neighbour not ipi", 32'(popIsIpi), 32'd0);
    step(0, '0, 1);

    // R7: several full laps of fill then drain
    for (int lap = 0; lap < 4; lap++) begin
      for (int i = 0; i < DEPTH; i++) step(1, 31'(lap * 100 + i + 1), 0);
      for (int i = 0; i < DEPTH; i++) begin
        check("R7 lap order", 32'(popData), 32'(lap * 100 + i + 1));
        step(0, '0, 1);
      end
      check("R7 stale slots invalid", 32'(popEmpty), 32'd1);
    end

    // R9: full ring, write plus pop
    for (int i = 0; i < DEPTH; i++) step(1, 31'(500 + i), 0);
    step(1, 31'h7777, 1);
    check("R9 no overflow", 32'(overflow), 32'd0);
    check("R9 head advanced", 32'(popData), 32'd501);

    // R3: full ring, extra write dropped
    step(1, 31'h6666, 0);
    check("R3 flag set", 32'(overflow), 32'd1);
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1);
    check("R3 drained", 32'(popEmpty), 32'd1);
    step(0, '0, 0);
    check("R3 sticky", 32'(overflow), 32'd1);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      v = ($urandom % 8 == 0) ? IPI : 31'($urandom);
      step(($urandom % 100) < 55, v, ($urandom % 100) < 50);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule